// File: doc/BRIEF.md
# Scanline Prefetcher with Nibble Unpacker

This block links a shared external video memory to the pixel path of a 640x480 display that uses 4 bits per pixel. Memory cannot deliver data at the live pixel rate. The block therefore loads the whole packed content of the next scanline into on-chip storage while the current scanline is on screen. Each active line holds 640 pixels, which is 320 bytes. The memory returns 16 bits per read: the even byte and the odd byte of a pair. A line therefore takes 160 word reads. These must all complete within one line period of about 31.77 us.

Two line banks alternate roles. One bank feeds the display while the other is being filled, and the roles swap on every line-start strobe from the timing generator. At the pixel clock, a small state machine walks the displayed bank one pixel per active cycle. Within each byte it takes the high nibble first. If a fill is still incomplete when the banks swap, a sticky underrun flag is raised and the fill restarts for the new line. Responses still in flight from the abandoned fill are discarded, so they cannot corrupt the new fill.

The fill controller has four states: FILL_IDLE, FILL_ISSUE, FILL_WAIT and FILL_FULL.
- FILL_IDLE is the state after reset. It moves to FILL_ISSUE on a line start.
- FILL_ISSUE moves to FILL_WAIT when the last of the 160 requests is accepted.
- FILL_WAIT moves to FILL_FULL when the last response is stored.
- A line start forces FILL_ISSUE from any state.

The draw sequencer has three states: DRAW_WAIT, DRAW_RUN and DRAW_SPENT.
- DRAW_WAIT is the state at line start, before any pixel has been shown. It moves to DRAW_RUN on the first emitted pixel.
- DRAW_WAIT or DRAW_RUN moves to DRAW_SPENT when the 640th pixel is emitted.
- A line start forces DRAW_WAIT from any state.

Top module: `scanline_prefetcher`

## Requirements
- R1: While reset is held and directly after it, fetch_req is 0, pix_out is 0 and underrun is 0. Reset also clears a set underrun flag.
- R2: On a clock with line_start high, next_base is captured. From the next cycle, fetch_req is high and fetch_addr equals that base. fetch_addr rises by exactly one after each cycle with fetch_req and fetch_gnt both high, and otherwise holds.
- R3: Responses (rd_valid high) arrive in request order, at least one cycle after their grant. The k-th stored response of a fill becomes word k of the line. rd_data[15:8] is the even (earlier) byte and rd_data[7:0] is the odd byte.
- R4: Data fetched after one line_start is displayed only after the following line_start: the bank being filled and the bank being shown swap at each line_start.
- R5: Pixels 4k, 4k+1, 4k+2 and 4k+3 of a line are rd_data bits [15:12], [11:8], [7:4] and [3:0] of word k. The high nibble comes first within each byte.
- R6: pix_out is registered. A cycle with active_video high (and line_start low) puts the next pixel of the line on pix_out in the following cycle, advancing one pixel per such cycle.
- R7: A cycle with active_video low gives pix_out = 0 in the following cycle and does not advance the pixel pointer, so a gap inside the active region resumes at the next pixel.
- R8: Once 640 pixels of a line have been emitted, pix_out stays 0 until the next line_start, even if active_video remains high.
- R9: A line_start cycle gives pix_out = 0 in the following cycle and rewinds the pixel pointer to pixel 0, whatever active_video is.
- R10: If line_start arrives while a fill is in FILL_ISSUE or FILL_WAIT, underrun goes high on the next cycle and stays high until reset.
- R11: Responses to requests granted before a line_start (including one granted in that very cycle) are discarded and never written into the new fill.
- R12: Exactly 160 requests are accepted per fill. After the last one, fetch_req stays low until the next line_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each scanline |
| active_video | input | 1 | High during visible pixel cycles |
| next_base | input | 18 | Word address of the line to fetch, sampled at line_start |
| fetch_req | output | 1 | Word read request toward the memory arbiter |
| fetch_addr | output | 18 | Word address of the pending request |
| fetch_gnt | input | 1 | Arbiter accepts the request in this cycle |
| rd_valid | input | 1 | Read data of the oldest outstanding request is present |
| rd_data | input | 16 | Read word: even byte in [15:8], odd byte in [7:0] |
| pix_out | output | 4 | Palette index of the current pixel |
| underrun | output | 1 | Sticky flag: a fill missed its line deadline |

## Verification
The embedded properties check the following on every clock: the request address loads from the base at line start, steps by one per accepted request and holds otherwise; the request count stays within 160; underrun never clears once set and rises only after a line start; the write bank never equals the display bank; and pix_out is zero after blanking, after line start and after the pixel count runs out. Only the bench's scenarios can show that the right data ends up on screen. That covers the nibble and byte order, the one-line ping-pong delay under steady, alternating and bursty grant and response patterns, and the resumption of the pixel stream after a blanking gap. It also covers the dropping of stale responses after a starved line, which only appears in the pixel content of the line after the underrun.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;

    // Fill controller states
    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_ISSUE = 2'd1,
        FILL_WAIT  = 2'd2,
        FILL_FULL  = 2'd3
    } fill_state_t;

    // Draw sequencer states
    typedef enum logic [1:0] {
        DRAW_WAIT  = 2'd0,
        DRAW_RUN   = 2'd1,
        DRAW_SPENT = 2'd2
    } draw_state_t;

endpackage

// File: rtl/spf_fill_ctrl.sv
`timescale 1ns/1ps
module spf_fill_ctrl
    import spf_pkg::*;
#(
    parameter int WORDS  = 160,
    parameter int ADDR_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_start,
    input  logic [ADDR_W-1:0]         next_base,
    input  logic                      fetch_gnt,
    input  logic                      rd_valid,
    output logic                      fetch_req,
    output logic [ADDR_W-1:0]         fetch_addr,
    output logic                      wr_en,
    output logic                      wr_bank,
    output logic [$clog2(WORDS)-1:0]  wr_idx,
    output logic                      underrun
);

    localparam int CNT_W = $clog2(WORDS + 1);
    localparam int IDX_W = $clog2(WORDS);
    localparam int FLT_W = CNT_W + 1;

    fill_state_t        state_q, state_d;
    logic [CNT_W-1:0]   req_cnt_q;
    logic [CNT_W-1:0]   rsp_cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [FLT_W-1:0]   flight_q, flight_d;
    logic [FLT_W-1:0]   drop_q;
    logic               bank_q;
    logic               under_q;

    logic               filling;
    logic               accept;
    logic               store;
    logic               last_req;
    logic               last_rsp;

    assign filling  = (state_q == FILL_ISSUE) || (state_q == FILL_WAIT);
    assign accept   = fetch_req && fetch_gnt;
    assign store    = rd_valid && !line_start && (drop_q == '0) && filling;
    assign last_req = accept && (req_cnt_q == CNT_W'(WORDS - 1));
    assign last_rsp = store && (rsp_cnt_q == CNT_W'(WORDS - 1));
    assign flight_d = flight_q + FLT_W'(accept) - FLT_W'(rd_valid);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (line_start) begin
            state_d = FILL_ISSUE;
        end else begin
            unique case (state_q)
                FILL_IDLE:  state_d = FILL_IDLE;
                FILL_ISSUE: if (last_req) state_d = FILL_WAIT;
                FILL_WAIT:  if (last_rsp) state_d = FILL_FULL;
                FILL_FULL:  state_d = FILL_FULL;
                default:    state_d = FILL_IDLE;
            endcase
        end
    end

    // Counters, address, bank select and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            addr_q    <= '0;
            flight_q  <= '0;
            drop_q    <= '0;
            bank_q    <= 1'b0;
            under_q   <= 1'b0;
        end else begin
            flight_q <= flight_d;
            if (line_start) begin
                req_cnt_q <= '0;
                rsp_cnt_q <= '0;
                addr_q    <= next_base;
                bank_q    <= ~bank_q;
                // everything still outstanding belongs to the old fill
                drop_q    <= flight_d;
                if (filling) begin
                    under_q <= 1'b1;
                end
            end else begin
                if (accept) begin
                    req_cnt_q <= req_cnt_q + 1'b1;
                    addr_q    <= addr_q + 1'b1;
                end
                if (store) begin
                    rsp_cnt_q <= rsp_cnt_q + 1'b1;
                end
                if (rd_valid && (drop_q != '0)) begin
                    drop_q <= drop_q - 1'b1;
                end
            end
        end
    end

    // Outputs
    assign fetch_req  = (state_q == FILL_ISSUE);
    assign fetch_addr = addr_q;
    assign wr_en      = store;
    assign wr_bank    = bank_q;
    assign wr_idx     = IDX_W'(rsp_cnt_q);
    assign underrun   = under_q;

    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (fetch_addr == $past(next_base)) && fetch_req); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !line_start) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !line_start) |=> $stable(fetch_addr)); // R2
    AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_cnt_q <= CNT_W'(WORDS)); // R12
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R10
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(line_start)); // R10
    AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q <= flight_q); // R11

endmodule

// File: rtl/spf_line_banks.sv
`timescale 1ns/1ps
module spf_line_banks #(
    parameter int WORDS = 160,
    parameter int MEM_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_bank,
    input  logic [$clog2(WORDS)-1:0]  wr_idx,
    input  logic [MEM_W-1:0]          wr_data,
    input  logic                      rd_bank,
    input  logic [$clog2(WORDS)-1:0]  rd_idx,
    output logic [MEM_W-1:0]          rd_word
);

    localparam int BANKS = 2;

    logic [MEM_W-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [MEM_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_idx] <= wr_data;
            end
        end

        assign bank_rd[b] = mem[rd_idx];
    end

    assign rd_word = bank_rd[rd_bank];

    AST_BANK_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != rd_bank)); // R4
    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < WORDS)); // R3

endmodule

// File: rtl/spf_pixel_shifter.sv
`timescale 1ns/1ps
module spf_pixel_shifter
    import spf_pkg::*;
#(
    parameter int PIX_PER_LINE = 640,
    parameter int PIX_BITS     = 4,
    parameter int MEM_W        = 16,
    parameter int WORDS        = 160
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_start,
    input  logic                      active_video,
    input  logic [MEM_W-1:0]          rd_word,
    output logic [$clog2(WORDS)-1:0]  rd_idx,
    output logic [PIX_BITS-1:0]       pix_out
);

    localparam int PIX_PER_WORD = MEM_W / PIX_BITS;
    localparam int SEL_W        = $clog2(PIX_PER_WORD);
    localparam int PCNT_W       = $clog2(PIX_PER_LINE + 1);
    localparam int IDX_W        = $clog2(WORDS);

    draw_state_t         dst_q, dst_d;
    logic [PCNT_W-1:0]   pcnt_q;
    logic                emit;
    logic                last_pix;
    logic [SEL_W-1:0]    lane;
    logic [PIX_BITS-1:0] nib;

    assign emit     = active_video && !line_start && (dst_q != DRAW_SPENT);
    assign last_pix = (pcnt_q == PCNT_W'(PIX_PER_LINE - 1));
    assign lane     = pcnt_q[SEL_W-1:0];
    assign rd_idx   = (dst_q == DRAW_SPENT) ? '0 : IDX_W'(pcnt_q >> SEL_W);

    // Leftmost pixel of a word sits in its top bits
    always_comb begin
        nib = rd_word[MEM_W - 1 - int'(lane) * PIX_BITS -: PIX_BITS];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q <= DRAW_WAIT;
        end else begin
            dst_q <= dst_d;
        end
    end

    // Next-state logic
    always_comb begin
        dst_d = dst_q;
        if (line_start) begin
            dst_d = DRAW_WAIT;
        end else begin
            unique case (dst_q)
                DRAW_WAIT, DRAW_RUN: begin
                    if (emit && last_pix) begin
                        dst_d = DRAW_SPENT;
                    end else if (emit) begin
                        dst_d = DRAW_RUN;
                    end
                end
                DRAW_SPENT: dst_d = DRAW_SPENT;
                default:    dst_d = DRAW_WAIT;
            endcase
        end
    end

    // Pointer and registered pixel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q  <= '0;
            pix_out <= '0;
        end else begin
            pix_out <= emit ? nib : '0;
            if (line_start) begin
                pcnt_q <= '0;
            end else if (emit) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active_video |=> (pix_out == '0)); // R7
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_video && !line_start) |=> $stable(pcnt_q)); // R7
    AST_LS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (pix_out == '0) && (pcnt_q == '0)); // R9
    AST_SPENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_q == DRAW_SPENT && !line_start) |=> (pix_out == '0)); // R8
    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PCNT_W'(PIX_PER_LINE)); // R8

endmodule

// File: rtl/scanline_prefetcher.sv
`timescale 1ns/1ps
module scanline_prefetcher #(
    parameter int PIX_PER_LINE = 640,
    parameter int PIX_BITS     = 4,
    parameter int MEM_W        = 16,
    parameter int ADDR_W       = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic                 active_video,
    input  logic [ADDR_W-1:0]    next_base,
    output logic                 fetch_req,
    output logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 fetch_gnt,
    input  logic                 rd_valid,
    input  logic [MEM_W-1:0]     rd_data,
    output logic [PIX_BITS-1:0]  pix_out,
    output logic                 underrun
);

    localparam int PIX_PER_WORD = MEM_W / PIX_BITS;
    localparam int WORDS        = PIX_PER_LINE / PIX_PER_WORD;
    localparam int IDX_W        = $clog2(WORDS);

    logic             wr_en;
    logic             wr_bank;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [MEM_W-1:0] rd_word;

    spf_fill_ctrl #(
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .next_base  (next_base),
        .fetch_gnt  (fetch_gnt),
        .rd_valid   (rd_valid),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_idx     (wr_idx),
        .underrun   (underrun)
    );

    spf_line_banks #(
        .WORDS (WORDS),
        .MEM_W (MEM_W)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (rd_data),
        .rd_bank (~wr_bank),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    spf_pixel_shifter #(
        .PIX_PER_LINE (PIX_PER_LINE),
        .PIX_BITS     (PIX_BITS),
        .MEM_W        (MEM_W),
        .WORDS        (WORDS)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .active_video (active_video),
        .rd_word      (rd_word),
        .rd_idx       (rd_idx),
        .pix_out      (pix_out)
    );

endmodule

// File: tb/scanline_prefetcher_tb_top.sv
`timescale 1ns/1ps
module scanline_prefetcher_tb_top;

    localparam int PIX      = 640;
    localparam int WORDS    = 160;
    localparam int ADDR_W   = 18;
    localparam int LINE_LEN = 900;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              line_start;
    logic              active_video;
    logic [ADDR_W-1:0] next_base;
    logic              fetch_gnt;
    logic              rd_valid;
    logic [15:0]       rd_data;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic [3:0]        pix_out;
    logic              underrun;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    scanline_prefetcher dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .active_video (active_video),
        .next_base    (next_base),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_gnt    (fetch_gnt),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .pix_out      (pix_out),
        .underrun     (underrun)
    );

    // Memory model: outstanding addresses in grant order
    logic [ADDR_W-1:0] pend[$];

    function automatic logic [15:0] word_of(input logic [ADDR_W-1:0] a);
        return 16'((int'(a) * 40503 + 4660) ^ (int'(a) >>> 3));
    endfunction

    // Reference model state
    int          m_state;   // 0 idle, 1 issuing, 2 waiting, 3 full
    int          m_req, m_rsp, m_drop, m_flight, m_cnt;
    bit          m_show, m_under;
    logic [ADDR_W-1:0] m_addr;
    int          m_buf   [2][WORDS];
    bit          m_known [2][WORDS];
    int          m_pix;
    bit          m_pix_known;
    string       m_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_req = 0; m_rsp = 0; m_drop = 0; m_flight = 0;
            m_cnt = 0; m_show = 1'b1; m_under = 1'b0; m_addr = '0;
            m_pix = 0; m_pix_known = 1'b1; m_tag = "R1";
        end else begin
            bit acc;
            int fb, w, l;
            acc = (m_state == 1) && fetch_gnt;
            // display side, using the bank shown before this edge
            if (line_start) begin
                m_pix = 0; m_pix_known = 1'b1; m_tag = "R9"; m_cnt = 0;
            end else if (active_video && m_cnt < PIX) begin
                w = m_cnt / 4;
                l = m_cnt % 4;
                m_pix_known = m_known[m_show][w];
                m_pix = (m_buf[m_show][w] >> (12 - 4 * l)) & 15;
                m_tag = m_under ? "R11 R3 R4 R5 R6" : "R3 R4 R5 R6";
                m_cnt++;
            end else begin
                m_pix = 0; m_pix_known = 1'b1;
                m_tag = (m_cnt >= PIX) ? "R8" : "R7";
            end
            // fill side
            fb = m_show ? 0 : 1;
            if (line_start) begin
                if (m_state == 1 || m_state == 2) m_under = 1'b1;
                m_drop  = m_flight + int'(acc) - int'(rd_valid);
                m_state = 1; m_req = 0; m_rsp = 0;
                m_addr  = next_base;
                m_show  = !m_show;
            end else begin
                if (rd_valid && m_drop > 0) begin
                    m_drop--;
                end else if (rd_valid && (m_state == 1 || m_state == 2)) begin
                    m_buf[fb][m_rsp]   = int'(rd_data);
                    m_known[fb][m_rsp] = 1'b1;
                    m_rsp++;
                    if (m_rsp == WORDS) m_state = 3;
                end
                if (acc) begin
                    m_addr++;
                    m_req++;
                    if (m_req == WORDS) m_state = 2;
                end
            end
            m_flight = m_flight + int'(acc) - int'(rd_valid);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    task automatic compare_all();
        if (m_pix_known) chk(pix_out == 4'(m_pix), m_tag, "pix_out", int'(pix_out), m_pix);
        chk(fetch_req == (m_state == 1), "R12", "fetch_req", int'(fetch_req), int'(m_state == 1));
        if (m_state == 1) chk(fetch_addr == m_addr, "R2", "fetch_addr", int'(fetch_addr), int'(m_addr));
        chk(underrun == m_under, "R10", "underrun", int'(underrun), int'(m_under));
    endtask

    // gmode: 0 grant always, 1 every other cycle, 2 every eighth cycle
    // rmode: 0 respond at once, 1 respond every third cycle
    task automatic run_line(input logic [ADDR_W-1:0] base, input int gmode, input int rmode,
                            input int gap, input int ext, input bit count_reqs);
        int nreq;
        nreq = 0;
        for (int c = 0; c < LINE_LEN; c++) begin
            @(negedge clk);
            compare_all();
            line_start   = (c == 0);
            next_base    = base;
            active_video = (c >= 100 && c < 100 + PIX + gap + ext)
                           && !(gap > 0 && c >= 300 && c < 300 + gap);
            rd_valid = 1'b0;
            if (pend.size() > 0 && (rmode == 0 || c % 3 == 0)) begin
                rd_valid = 1'b1;
                rd_data  = word_of(pend.pop_front());
            end
            case (gmode)
                0:       fetch_gnt = 1'b1;
                1:       fetch_gnt = (c % 2 == 1);
                default: fetch_gnt = (c % 8 == 0);
            endcase
            if (fetch_req && fetch_gnt) begin
                pend.push_back(fetch_addr);
                if (c > 0) nreq++;
            end
        end
        // R12: a full fill accepts exactly one line of word requests
        if (count_reqs) chk(nreq == WORDS, "R12", "requests per line", nreq, WORDS);
    endtask

    initial begin
        rst_n = 1'b0; line_start = 1'b0; active_video = 1'b0; next_base = '0;
        fetch_gnt = 1'b0; rd_valid = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        chk(pix_out == 4'd0, "R1", "pix_out in reset", int'(pix_out), 0);
        chk(fetch_req == 1'b0, "R1", "fetch_req in reset", int'(fetch_req), 0);
        chk(underrun == 1'b0, "R1", "underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;

        run_line(18'h00100, 0, 0, 0, 0, 1'b1);
        run_line(18'h02000, 1, 1, 5, 0, 1'b1);   // R7 gap mid-line
        run_line(18'h3FF00, 0, 1, 0, 12, 1'b1);  // R8 active past the line end
        run_line(18'h00500, 2, 0, 0, 0, 1'b0);   // starved fill
        run_line(18'h00600, 0, 0, 0, 0, 1'b1);   // R11 stale response dropped
        chk(underrun == 1'b1, "R10", "underrun sticky", int'(underrun), 1);
        run_line(18'h00700, 1, 0, 3, 4, 1'b1);
        run_line(18'h00800, 0, 1, 0, 0, 1'b1);

        @(negedge clk);
        compare_all();
        rst_n = 1'b0; line_start = 1'b0; active_video = 1'b0;
        fetch_gnt = 1'b0; rd_valid = 1'b0;
        pend.delete();
        @(negedge clk);
        chk(underrun == 1'b0, "R1", "underrun cleared by reset", int'(underrun), 0);
        chk(pix_out == 4'd0, "R1", "pix_out after reset", int'(pix_out), 0);
        rst_n = 1'b1;

        run_line(18'h00900, 0, 0, 0, 0, 1'b1);
        run_line(18'h00A00, 1, 1, 0, 0, 1'b1);
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule